// File: doc/BRIEF.md
# Dual-Port Collision Arbiter

This block sits beside a shared storage array that two independent agents, called left and right, reach through their own ports. Each port presents a select, a write strobe and an address every clock cycle. When both ports select the same location at once, the block chooses one of them and sends an active-low busy indication to the other. Arbitration is modelled synchronously, and port timing is counted in clock cycles.

The winner is the port that was present at the contested location first. A port counts as present once it has held its select and its address unchanged across a clock edge. Two cases are covered this way. In the first, the addresses already agree and one select rises before the other. In the second, both selects are already on and one address moves onto the other. If both ports arrive in the same cycle, the left port wins. A grant lasts until the collision ends, so a port that arrives later cannot take it over.

A static strap sets the role of the busy pins. In master mode the block computes busy and drives it out. It also uses busy internally to block the losing port's write. In slave mode the busy outputs stay inactive (high). The busy inputs, driven by an external master, then block writes on their own port. Reads are never blocked. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `dual_port_arbiter`

## Requirements
- R1: After reset, with both ports idle, both busy outputs are high and both write-qualify outputs are low.
- R2: A busy output is low only when both selects are high and the two addresses are equal. It is never low for a port that is not in a collision.
- R3: If the addresses are already equal and one port's select rises at least one cycle before the other's, the later port sees its busy output go low in the cycle its select rises. The earlier port's busy output stays high.
- R4: If both selects are already high and one port moves its address onto the other port's unchanged address, the moving port's busy output goes low in that same cycle.
- R5: If both ports select the same address in the same cycle, coming from a state without a collision, the left port wins and only the right busy output goes low.
- R6: For as long as the collision lasts, the grant stays with the port that first won it. The loser's busy output remains low every cycle.
- R7: The loser's busy output returns high in the same cycle that the addresses stop matching or the winner's select drops.
- R8: In master mode the loser's write-qualify output is low even while its write strobe is high. The winner's write still passes.
- R9: In slave mode (strap low) both busy outputs stay high regardless of collisions. A low busy input blocks that port's write-qualify output, and a high busy input lets the write pass.
- R10: A read, meaning select high with the write strobe low, always raises that port's read-qualify output, whatever the busy state is in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | Strap: 1 drives busy out, 0 accepts busy in |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left port write strobe (0 means read) |
| l_addr | input | ADDR_W | Left port address |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right port write strobe (0 means read) |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in_n | input | 1 | Left busy from an external master (slave mode) |
| r_busy_in_n | input | 1 | Right busy from an external master (slave mode) |
| l_busy_out_n | output | 1 | Left busy, active low (master mode) |
| r_busy_out_n | output | 1 | Right busy, active low (master mode) |
| l_wr_ok | output | 1 | Left write allowed this cycle |
| r_wr_ok | output | 1 | Right write allowed this cycle |
| l_rd_ok | output | 1 | Left read allowed this cycle |
| r_rd_ok | output | 1 | Right read allowed this cycle |

## Verification
The bench uses a 2-bit address and sweeps every address pair under three arrival patterns:
- Both ports arriving in the same cycle separates an equal-address collision (R5) from the no-collision case (R2).
- Each port arriving one cycle ahead of the other shows that the earlier select wins (R3).
- Each port in turn moving its address onto the other's static address shows that the earlier address wins (R4).

Directed sequences then hold a collision for several cycles (R6) and break it in both ways, by address change and by winner release (R7). Write and read gating is then tried in master mode with internal busy (R8) and in slave mode with external busy (R9, R10).

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned SIDES = 2;
  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;
endpackage

// File: rtl/dpa_port_track.sv
// Remembers one port's select and address from the previous cycle and
// reports whether the port has been sitting on its current location.
module dpa_port_track #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel;
      addr_q <= addr;
    end
  end

  assign settled = sel && sel_q && (addr_q == addr);
endmodule

// File: rtl/dpa_judge.sv
// Decides which port owns a contested location and keeps that owner
// until the collision ends.
module dpa_judge
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_settled,
  input  logic              r_settled,
  output owner_e            grant
);
  owner_e owner_q;
  logic   collide;

  assign collide = l_sel && r_sel && (l_addr == r_addr);

  always_comb begin
    if (!collide || !rst_n) begin
      grant = OWN_NONE;
    end else if (owner_q != OWN_NONE) begin
      grant = owner_q;                // held grant: late arrivals cannot steal
    end else if (r_settled && !l_settled) begin
      grant = OWN_RIGHT;              // right was there first
    end else begin
      grant = OWN_LEFT;               // left first, or a tie
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= grant;
  end
endmodule

// File: rtl/dpa_busy_io.sv
// Turns the grant into busy pins and qualifies reads and writes per side,
// according to the master/slave strap.
module dpa_busy_io
  import dpa_pkg::*;
(
  input  logic             master_mode,
  input  owner_e           grant,
  input  logic [SIDES-1:0] sel,
  input  logic [SIDES-1:0] wr,
  input  logic [SIDES-1:0] busy_in_n,
  output logic [SIDES-1:0] busy_out_n,
  output logic [SIDES-1:0] wr_ok,
  output logic [SIDES-1:0] rd_ok
);
  logic [SIDES-1:0] lost;

  assign lost[SIDE_L] = (grant == OWN_RIGHT);
  assign lost[SIDE_R] = (grant == OWN_LEFT);

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic blocked;
    assign blocked       = master_mode ? lost[s] : !busy_in_n[s];
    assign busy_out_n[s] = !(master_mode && lost[s]);
    assign wr_ok[s]      = sel[s] && wr[s] && !blocked;
    assign rd_ok[s]      = sel[s] && !wr[s];
  end
endmodule

// File: rtl/dual_port_arbiter.sv
module dual_port_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_out_n,
  output logic              r_busy_out_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok,
  output logic              l_rd_ok,
  output logic              r_rd_ok
);
  logic [SIDES-1:0]  sel_v;
  logic [ADDR_W-1:0] addr_v [SIDES];
  logic [SIDES-1:0]  settled;
  logic [SIDES-1:0]  busy_o;
  logic [SIDES-1:0]  wr_o;
  logic [SIDES-1:0]  rd_o;
  owner_e            grant;

  assign sel_v          = {r_sel, l_sel};
  assign addr_v[SIDE_L] = l_addr;
  assign addr_v[SIDE_R] = r_addr;

  for (genvar s = 0; s < SIDES; s++) begin : g_track
    dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_v[s]),
      .addr    (addr_v[s]),
      .settled (settled[s])
    );
  end

  dpa_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .l_sel     (l_sel),
    .l_addr    (l_addr),
    .r_sel     (r_sel),
    .r_addr    (r_addr),
    .l_settled (settled[SIDE_L]),
    .r_settled (settled[SIDE_R]),
    .grant     (grant)
  );

  dpa_busy_io u_io (
    .master_mode (master_mode),
    .grant       (grant),
    .sel         (sel_v),
    .wr          ({r_wr, l_wr}),
    .busy_in_n   ({r_busy_in_n, l_busy_in_n}),
    .busy_out_n  (busy_o),
    .wr_ok       (wr_o),
    .rd_ok       (rd_o)
  );

  assign l_busy_out_n = busy_o[SIDE_L];
  assign r_busy_out_n = busy_o[SIDE_R];
  assign l_wr_ok      = wr_o[SIDE_L];
  assign r_wr_ok      = wr_o[SIDE_R];
  assign l_rd_ok      = rd_o[SIDE_L];
  assign r_rd_ok      = rd_o[SIDE_R];
endmodule

// File: rtl/dual_port_arbiter_chk.sv
module dual_port_arbiter_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_sel,
  input logic              l_wr,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_sel,
  input logic              r_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_out_n,
  input logic              r_busy_out_n,
  input logic              l_wr_ok,
  input logic              r_wr_ok,
  input logic              l_rd_ok,
  input logic              r_rd_ok
);
  logic collide;
  logic live_q;

  assign collide = l_sel && r_sel && (l_addr == r_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  a_r2_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_out_n || !r_busy_out_n) |-> collide);

  a_r5_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_out_n && !r_busy_out_n));

  a_r6_grant_held_r: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && master_mode && $past(master_mode) && $past(!r_busy_out_n) && collide)
      |-> !r_busy_out_n);

  a_r6_grant_held_l: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && master_mode && $past(master_mode) && $past(!l_busy_out_n) && collide)
      |-> !l_busy_out_n);

  a_r8_loser_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_out_n |-> !l_wr_ok) and (!r_busy_out_n |-> !r_wr_ok));

  a_r9_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_out_n && r_busy_out_n));

  a_r10_reads_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_sel && !l_wr) |-> l_rd_ok) and ((r_sel && !r_wr) |-> r_rd_ok));
endmodule

bind dual_port_arbiter dual_port_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .master_mode  (master_mode),
  .l_sel        (l_sel),
  .l_wr         (l_wr),
  .l_addr       (l_addr),
  .r_sel        (r_sel),
  .r_wr         (r_wr),
  .r_addr       (r_addr),
  .l_busy_out_n (l_busy_out_n),
  .r_busy_out_n (r_busy_out_n),
  .l_wr_ok      (l_wr_ok),
  .r_wr_ok      (r_wr_ok),
  .l_rd_ok      (l_rd_ok),
  .r_rd_ok      (r_rd_ok)
);

// File: tb/sim_dual_port_arbiter.sv
`timescale 1ns/1ps
module sim_dual_port_arbiter;
  localparam int AW = 2;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_sel = 1'b0, l_wr = 1'b0, r_sel = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic l_busy_out_n, r_busy_out_n, l_wr_ok, r_wr_ok, l_rd_ok, r_rd_ok;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dual_port_arbiter #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok),
    .l_rd_ok(l_rd_ok), .r_rd_ok(r_rd_ok)
  );

  task automatic check(input string req, input string what, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // apply inputs after a falling edge, sample 1 ns later
  task automatic drive(input logic ls, input logic lw, input logic [AW-1:0] la,
                       input logic rs, input logic rw, input logic [AW-1:0] ra);
    @(negedge clk);
    l_sel = ls; l_wr = lw; l_addr = la;
    r_sel = rs; r_wr = rw; r_addr = ra;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "l busy in reset", l_busy_out_n, 1'b1);
    check("R1", "r busy in reset", r_busy_out_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    check("R1", "l busy after reset", l_busy_out_n, 1'b1);
    check("R1", "r busy after reset", r_busy_out_n, 1'b1);
    check("R1", "l wr_ok idle", l_wr_ok, 1'b0);
    check("R1", "r wr_ok idle", r_wr_ok, 1'b0);

    // R5 / R2: same-cycle arrival over all address pairs
    for (int la = 0; la < NA; la++) begin
      for (int ra = 0; ra < NA; ra++) begin
        idle();
        drive(1'b1, 1'b0, AW'(la), 1'b1, 1'b0, AW'(ra));
        check("R5", "tie l busy", l_busy_out_n, 1'b1);
        check(la == ra ? "R5" : "R2", "tie r busy", r_busy_out_n, la != ra);
      end
    end

    // R3 / R2: select-first arrival, either side first
    for (int first = 0; first < 2; first++) begin
      for (int la = 0; la < NA; la++) begin
        for (int ra = 0; ra < NA; ra++) begin
          idle();
          if (first == 0) drive(1'b1, 1'b0, AW'(la), 1'b0, 1'b0, AW'(ra));
          else            drive(1'b0, 1'b0, AW'(la), 1'b1, 1'b0, AW'(ra));
          check("R2", "lone port l busy", l_busy_out_n, 1'b1);
          check("R2", "lone port r busy", r_busy_out_n, 1'b1);
          drive(1'b1, 1'b0, AW'(la), 1'b1, 1'b0, AW'(ra));
          check("R3", "late l busy", l_busy_out_n, !(la == ra && first == 1));
          check("R3", "late r busy", r_busy_out_n, !(la == ra && first == 0));
        end
      end
    end

    // R4: address-first arrival, either side moves
    for (int mover = 0; mover < 2; mover++) begin
      for (int a = 0; a < NA; a++) begin
        idle();
        drive(1'b1, 1'b0, AW'(a), 1'b1, 1'b0, AW'(a ^ 1));
        check("R2", "apart l busy", l_busy_out_n, 1'b1);
        if (mover == 1) drive(1'b1, 1'b0, AW'(a), 1'b1, 1'b0, AW'(a));
        else            drive(1'b1, 1'b0, AW'(a ^ 1), 1'b1, 1'b0, AW'(a ^ 1));
        check("R4", "mover l busy", l_busy_out_n, mover != 0);
        check("R4", "mover r busy", r_busy_out_n, mover != 1);
      end
    end

    // R6: right wins, left stays on; grant held
    idle();
    drive(1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2);
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2);
      check("R6", "held l busy", l_busy_out_n, 1'b0);
      check("R6", "held r busy", r_busy_out_n, 1'b1);
    end
    // R7: address change ends the collision the same cycle
    drive(1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd2);
    check("R7", "addr split l busy", l_busy_out_n, 1'b1);
    // R7: winner drops its select
    idle();
    drive(1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 2'd3);
    drive(1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 2'd3);
    check("R7", "before release r busy", r_busy_out_n, 1'b0);
    drive(1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 2'd3);
    check("R7", "winner released r busy", r_busy_out_n, 1'b1);

    // R8 / R10: master write gating, left wins
    idle();
    drive(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0);
    drive(1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 2'd0);
    check("R8", "loser r wr_ok", r_wr_ok, 1'b0);
    check("R8", "winner l wr_ok", l_wr_ok, 1'b1);
    drive(1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 2'd0);
    check("R10", "loser r rd_ok", r_rd_ok, 1'b1);
    check("R10", "loser r busy still low", r_busy_out_n, 1'b0);

    // R9 / R10: slave mode
    idle();
    master_mode = 1'b0;
    drive(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 2'd1);
    check("R9", "slave l busy out", l_busy_out_n, 1'b1);
    check("R9", "slave r busy out", r_busy_out_n, 1'b1);
    check("R9", "slave r wr_ok busy_in high", r_wr_ok, 1'b1);
    @(negedge clk);
    r_busy_in_n = 1'b0;
    #1;
    check("R9", "slave r wr_ok busy_in low", r_wr_ok, 1'b0);
    check("R9", "slave l wr_ok unaffected", l_wr_ok, 1'b1);
    @(negedge clk);
    l_busy_in_n = 1'b0;
    #1;
    check("R9", "slave l wr_ok busy_in low", l_wr_ok, 1'b0);
    drive(1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1);
    check("R10", "slave l rd_ok busy_in low", l_rd_ok, 1'b1);
    check("R10", "slave r rd_ok busy_in low", r_rd_ok, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule